// File: doc/BRIEF.md
# Parallel NOR Flash Query Probe

This block identifies a parallel NOR flash device by running its standard query protocol in hardware. After reset, or on a start pulse once a previous probe has finished, it drives a simple synchronous flash bus. The bus has a registered address, a write-data byte, a read-data byte, and write and read strobes. Read data is expected one cycle after the read strobe. The block works out how wide the device bus is, confirms the three-letter identification string, and walks the query table.

The results appear on registered outputs: the detected width, the 16-bit command-set code, the device size in bytes, and the erase-region geometry (block count and block size for up to four regions). A done flag rises when the probe ends. An error flag and a two-bit cause code tell a failed probe apart from a good one. The integrating logic supplies the query bytes on the low byte lane of the flash data bus.

Top module: `nor_query_probe`

## Requirements
- R1: Each query byte costs one bracket of bus cycles, in this order. First, a write of 0x98 at address 0x55 times the current width. Then a read at the query offset times the width. Then a write of 0xF0 at address 0, followed by a write of 0xFF at address 0. The byte is taken from `fl_rdata` in the cycle after the read strobe.
- R2: With `cfg_width` not equal to 1, 2 or 4, widths 1, 2 and 4 are tried in that order. The first width whose offset 0x10 returns 0x51 ('Q') is kept and shown on `det_width`.
- R3: If no tried width returns 'Q', or a preset width (1, 2 or 4) does not, the probe ends with `err`=1 and `err_cause`=0.
- R4: Offsets 0x11 and 0x12 must return 0x52 ('R') and 0x59 ('Y'). Otherwise the probe ends with `err_cause`=1, and no further offset is read.
- R5: `cmd_set` is assembled from offset 0x13 (low byte) and offset 0x14 (high byte).
- R6: `dev_size` equals 2 raised to the byte at offset 0x27, kept to SIZE_W bits. Exponents of SIZE_W or more give 0.
- R7: The interface code is formed from offset 0x28 (low byte) and offset 0x29 (high byte). One is added to it, modulo 2^16. If the sum has no bit in common with the detected width, the probe ends with `err_cause`=2.
- R8: Offset 0x2C gives the region count, shown on `region_num`. A count above MAX_REG ends the probe with `err_cause`=3. A count of 0 finishes the probe with no region reads.
- R9: Region r occupies offsets 0x2D+4r to 0x2D+4r+3. These hold the count field (low byte, then high byte) followed by the size field (low byte, then high byte). The reported block count is the field plus 1. The reported block size is 128 when the field is 0, and the field times 256 otherwise. Slot r sits at bits [17r+16:17r] of `blk_count_flat` and bits [24r+23:24r] of `blk_size_flat`. Unused slots read 0.
- R10: Every strobed bus address is a multiple of the width in use.
- R11: During reset, `done`, `err`, `fl_we` and `fl_re` are 0, and the probe starts by itself after reset. Once `done` is set, it holds until a start pulse. A start pulse then clears `done`, `err` and the results and runs a new probe. A start pulse while a probe runs has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the probe begins when it is released |
| start | input | 1 | Starts a new probe once `done` is set |
| cfg_width | input | 3 | Preset width 1, 2 or 4; any other value selects auto-detection |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_wdata | output | 8 | Command byte, low lane |
| fl_we | output | 1 | Write strobe |
| fl_re | output | 1 | Read strobe |
| fl_rdata | input | 8 | Read data, low lane, valid one cycle after `fl_re` |
| done | output | 1 | Probe finished |
| err | output | 1 | Probe failed |
| err_cause | output | 2 | 0 no 'Q', 1 bad ident, 2 interface, 3 too many regions |
| det_width | output | 3 | Width in use or detected |
| cmd_set | output | 16 | Command-set code |
| dev_size | output | SIZE_W | Device size in bytes |
| region_num | output | $clog2(MAX_REG+1) | Erase-region count |
| blk_count_flat | output | 17*MAX_REG | Blocks per region |
| blk_size_flat | output | 24*MAX_REG | Block size per region in bytes |

## Verification
Each query byte takes exactly seven cycles from the issue cycle to the cycle where the byte is used. A full probe is therefore seven cycles times the number of bytes read. Every result register is written before or together with `done`, so the bench waits for `done` at falling edges and only then compares the results. A bus monitor sampling on falling edges counts reads and checks the bracket order against an independent prediction of how many bytes the probe should fetch. The clearing of `done` is checked one cycle after the start edge.

// File: rtl/nqp_pkg.sv
`timescale 1ns/1ps
package nqp_pkg;
  localparam logic [7:0] QRY_CMD_OFS  = 8'h55;
  localparam logic [7:0] QRY_CMD_DATA = 8'h98;
  localparam logic [7:0] EXIT_CMD_A   = 8'hF0;
  localparam logic [7:0] EXIT_CMD_B   = 8'hFF;

  localparam logic [7:0] OFS_ID      = 8'h10;
  localparam logic [7:0] OFS_ID_R    = 8'h11;
  localparam logic [7:0] OFS_ID_Y    = 8'h12;
  localparam logic [7:0] OFS_CSET_LO = 8'h13;
  localparam logic [7:0] OFS_CSET_HI = 8'h14;
  localparam logic [7:0] OFS_SIZE    = 8'h27;
  localparam logic [7:0] OFS_IF_LO   = 8'h28;
  localparam logic [7:0] OFS_IF_HI   = 8'h29;
  localparam logic [7:0] OFS_NREG    = 8'h2C;
  localparam logic [7:0] OFS_REG0    = 8'h2D;

  localparam logic [7:0] CHAR_Q = 8'h51;
  localparam logic [7:0] CHAR_R = 8'h52;
  localparam logic [7:0] CHAR_Y = 8'h59;

  typedef enum logic [1:0] {
    CAUSE_NO_Q    = 2'd0,
    CAUSE_IDENT   = 2'd1,
    CAUSE_IFACE   = 2'd2,
    CAUSE_REGIONS = 2'd3
  } probe_cause_e;

  typedef enum logic [2:0] {
    AC_IDLE, AC_CMD, AC_READ, AC_CAPT, AC_EXIT_A, AC_EXIT_B
  } acc_state_e;

  typedef enum logic [1:0] {
    PR_ISSUE, PR_WAIT, PR_END
  } probe_state_e;
endpackage

// File: rtl/nqp_access.sv
`timescale 1ns/1ps
module nqp_access
  import nqp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [2:0]        width,
  input  logic [7:0]        ofs,
  input  logic [7:0]        rdata,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        wdata,
  output logic              we,
  output logic              re,
  output logic              vld,
  output logic [7:0]        byte_o
);
  acc_state_e st_q;
  logic [ADDR_W-1:0] amask;

  assign amask = ~(ADDR_W'(width) - ADDR_W'(1));

  function automatic logic [ADDR_W-1:0] scaled(input logic [7:0] o, input logic [2:0] w);
    return ADDR_W'(o) * ADDR_W'(w);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= AC_IDLE;
      addr   <= '0;
      wdata  <= '0;
      we     <= 1'b0;
      re     <= 1'b0;
      vld    <= 1'b0;
      byte_o <= '0;
    end else begin
      we  <= 1'b0;
      re  <= 1'b0;
      vld <= 1'b0;
      case (st_q)
        AC_IDLE: if (go) begin
          st_q  <= AC_CMD;
          we    <= 1'b1;
          addr  <= scaled(QRY_CMD_OFS, width) & amask;
          wdata <= QRY_CMD_DATA;
        end
        AC_CMD: begin
          st_q <= AC_READ;
          re   <= 1'b1;
          addr <= scaled(ofs, width) & amask;
        end
        AC_READ: st_q <= AC_CAPT;
        AC_CAPT: begin
          byte_o <= rdata;
          st_q   <= AC_EXIT_A;
          we     <= 1'b1;
          addr   <= '0;
          wdata  <= EXIT_CMD_A;
        end
        AC_EXIT_A: begin
          st_q  <= AC_EXIT_B;
          we    <= 1'b1;
          wdata <= EXIT_CMD_B;
        end
        default: begin
          st_q <= AC_IDLE;
          vld  <= 1'b1;
        end
      endcase
    end
  end

  // R1
  cmd_before_read_chk: assert property (@(posedge clk) disable iff (rst)
    re |-> ($past(we) && ($past(wdata) == QRY_CMD_DATA)));

  // R1
  exit_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    re |=> ##1 (we && (addr == '0) && (wdata == EXIT_CMD_A)) ##1 (we && (wdata == EXIT_CMD_B)));
endmodule

// File: rtl/nqp_region_regs.sv
`timescale 1ns/1ps
module nqp_region_regs #(
  parameter int MAX_REG = 4,
  parameter int IDX_W   = 2,
  parameter int CNT_W   = 17,
  parameter int BSZ_W   = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     wr,
  input  logic [IDX_W-1:0]         idx,
  input  logic                     is_size,
  input  logic [15:0]              raw,
  output logic [MAX_REG*CNT_W-1:0] cnt_flat,
  output logic [MAX_REG*BSZ_W-1:0] bsz_flat
);
  logic [CNT_W-1:0] cnt_q [MAX_REG];
  logic [BSZ_W-1:0] bsz_q [MAX_REG];

  always_ff @(posedge clk) begin
    for (int r = 0; r < MAX_REG; r++) begin
      if (rst || clr) begin
        cnt_q[r] <= '0;
        bsz_q[r] <= '0;
      end else if (wr && (idx == IDX_W'(r))) begin
        if (is_size)
          bsz_q[r] <= (raw == 16'd0) ? BSZ_W'(128) : BSZ_W'({raw, 8'h00});
        else
          cnt_q[r] <= CNT_W'(raw) + CNT_W'(1);
      end
    end
  end

  for (genvar g = 0; g < MAX_REG; g++) begin : g_pack
    assign cnt_flat[g*CNT_W +: CNT_W] = cnt_q[g];
    assign bsz_flat[g*BSZ_W +: BSZ_W] = bsz_q[g];
  end

  // R9
  size_granule_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && is_size) |=> (bsz_flat[idx*BSZ_W +: 7] == 7'd0));
endmodule

// File: rtl/nor_query_probe.sv
`timescale 1ns/1ps
module nor_query_probe
  import nqp_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SIZE_W  = 32,
  parameter int MAX_REG = 4,
  localparam int CNT_W  = 17,
  localparam int BSZ_W  = 24,
  localparam int RN_W   = $clog2(MAX_REG + 1),
  localparam int IDX_W  = (MAX_REG > 1) ? $clog2(MAX_REG) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [2:0]               cfg_width,
  output logic [ADDR_W-1:0]        fl_addr,
  output logic [7:0]               fl_wdata,
  output logic                     fl_we,
  output logic                     fl_re,
  input  logic [7:0]               fl_rdata,
  output logic                     done,
  output logic                     err,
  output logic [1:0]               err_cause,
  output logic [2:0]               det_width,
  output logic [15:0]              cmd_set,
  output logic [SIZE_W-1:0]        dev_size,
  output logic [RN_W-1:0]          region_num,
  output logic [MAX_REG*CNT_W-1:0] blk_count_flat,
  output logic [MAX_REG*BSZ_W-1:0] blk_size_flat
);
  probe_state_e st_q;
  probe_cause_e cause_q;
  logic [2:0]        width_q;
  logic              auto_q;
  logic [7:0]        ofs_q, lo_q, acc_byte, last_ofs;
  logic              acc_vld, begin_probe, preset, if_ok;
  logic [15:0]       if_inc;
  logic [IDX_W+1:0]  rel;
  logic              rg_wr;

  assign preset      = (cfg_width == 3'd1) || (cfg_width == 3'd2) || (cfg_width == 3'd4);
  assign begin_probe = start && (st_q == PR_END);
  assign if_inc      = {acc_byte, lo_q} + 16'd1;
  assign if_ok       = (if_inc & 16'(width_q)) != 16'd0;
  assign last_ofs    = OFS_REG0 + 8'(nreg_shift(region_num)) - 8'd1;
  assign rel         = (IDX_W+2)'(ofs_q - OFS_REG0);
  assign rg_wr       = (st_q == PR_WAIT) && acc_vld && (ofs_q >= OFS_REG0) && rel[0];

  function automatic logic [9:0] nreg_shift(input logic [RN_W-1:0] n);
    return 10'(n) << 2;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || begin_probe) begin
      st_q       <= PR_ISSUE;
      width_q    <= preset ? cfg_width : 3'd1;
      auto_q     <= !preset;
      ofs_q      <= OFS_ID;
      lo_q       <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
      cause_q    <= CAUSE_NO_Q;
      cmd_set    <= '0;
      dev_size   <= '0;
      region_num <= '0;
    end else begin
      case (st_q)
        PR_ISSUE: st_q <= PR_WAIT;
        PR_WAIT: if (acc_vld) begin
          st_q  <= PR_ISSUE;
          ofs_q <= ofs_q + 8'd1;
          lo_q  <= acc_byte;
          case (ofs_q)
            OFS_ID: if (acc_byte != CHAR_Q) begin
              ofs_q <= OFS_ID;
              if (auto_q && (width_q != 3'd4)) width_q <= width_q << 1;
              else begin st_q <= PR_END; done <= 1'b1; err <= 1'b1; cause_q <= CAUSE_NO_Q; end
            end
            OFS_ID_R, OFS_ID_Y:
              if (acc_byte != ((ofs_q == OFS_ID_R) ? CHAR_R : CHAR_Y)) begin
                st_q <= PR_END; done <= 1'b1; err <= 1'b1; cause_q <= CAUSE_IDENT;
              end
            OFS_CSET_HI: begin
              cmd_set <= {acc_byte, lo_q};
              ofs_q   <= OFS_SIZE;
            end
            OFS_SIZE: dev_size <= SIZE_W'(1) << acc_byte;
            OFS_IF_HI:
              if (!if_ok) begin
                st_q <= PR_END; done <= 1'b1; err <= 1'b1; cause_q <= CAUSE_IFACE;
              end else ofs_q <= OFS_NREG;
            OFS_NREG:
              if (acc_byte > 8'(MAX_REG)) begin
                st_q <= PR_END; done <= 1'b1; err <= 1'b1; cause_q <= CAUSE_REGIONS;
              end else begin
                region_num <= RN_W'(acc_byte);
                if (acc_byte == 8'd0) begin st_q <= PR_END; done <= 1'b1; end
              end
            default:
              if (ofs_q >= OFS_REG0 && ofs_q == last_ofs) begin
                st_q <= PR_END; done <= 1'b1;
              end
          endcase
        end
        default: ;
      endcase
    end
  end

  assign err_cause = cause_q;
  assign det_width = width_q;

  nqp_access #(.ADDR_W(ADDR_W)) u_access (
    .clk(clk), .rst(rst), .go(st_q == PR_ISSUE), .width(width_q), .ofs(ofs_q),
    .rdata(fl_rdata), .addr(fl_addr), .wdata(fl_wdata), .we(fl_we), .re(fl_re),
    .vld(acc_vld), .byte_o(acc_byte)
  );

  nqp_region_regs #(.MAX_REG(MAX_REG), .IDX_W(IDX_W), .CNT_W(CNT_W), .BSZ_W(BSZ_W)) u_regions (
    .clk(clk), .rst(rst), .clr(begin_probe), .wr(rg_wr), .idx(rel[IDX_W+1:2]),
    .is_size(rel[1]), .raw({acc_byte, lo_q}), .cnt_flat(blk_count_flat), .bsz_flat(blk_size_flat)
  );

  // R2
  width_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> ($countones(det_width) == 1 && det_width != 3'd0 && det_width <= 3'd4));

  // R8
  region_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (region_num <= RN_W'(MAX_REG)));

  // R10
  addr_align_chk: assert property (@(posedge clk) disable iff (rst)
    fl_re |-> ((fl_addr & (ADDR_W'(width_q) - ADDR_W'(1))) == '0));

  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
endmodule

// File: tb/nor_query_probe_tb.sv
`timescale 1ns/1ps
module nor_query_probe_tb;
  localparam int ADDR_W = 16, SIZE_W = 32, MAX_REG = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, start = 1'b0;
  logic [2:0] cfg_width = 3'd0;
  logic [ADDR_W-1:0] fl_addr;
  logic [7:0] fl_wdata, fl_rdata;
  logic fl_we, fl_re, done, err;
  logic [1:0] err_cause;
  logic [2:0] det_width;
  logic [15:0] cmd_set;
  logic [SIZE_W-1:0] dev_size;
  logic [2:0] region_num;
  logic [MAX_REG*17-1:0] blk_count_flat;
  logic [MAX_REG*24-1:0] blk_size_flat;

  nor_query_probe #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .MAX_REG(MAX_REG)) u_dut (
    .clk(clk), .rst(rst), .start(start), .cfg_width(cfg_width),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata),
    .done(done), .err(err), .err_cause(err_cause), .det_width(det_width), .cmd_set(cmd_set),
    .dev_size(dev_size), .region_num(region_num), .blk_count_flat(blk_count_flat),
    .blk_size_flat(blk_size_flat)
  );

  // flash model: true width tw, query table tbl
  int tw = 2;
  logic [7:0] tbl [80];
  logic qmode = 1'b0;

  function automatic logic [7:0] byte_at(input logic [ADDR_W-1:0] a);
    int idx;
    if (int'(a) % tw != 0) return 8'h00;
    idx = int'(a) / tw;
    return (idx < 80) ? tbl[idx] : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (fl_we) begin
      if (fl_wdata == 8'h98 && int'(fl_addr) == 85 * tw) qmode <= 1'b1;
      else if (fl_addr == '0 && (fl_wdata == 8'hF0 || fl_wdata == 8'hFF)) qmode <= 1'b0;
    end
    if (fl_re) fl_rdata <= qmode ? byte_at(fl_addr) : 8'hFF;
  end

  // bus monitor
  logic mon_clr = 1'b1;
  int reads, viol, align_viol, last_w, pend;
  always @(negedge clk) begin
    if (mon_clr) begin
      reads = 0; viol = 0; align_viol = 0; last_w = 0; pend = 0;
    end else if (fl_re) begin
      reads++;
      if (last_w == 0) viol++;
      else if (int'(fl_addr) % last_w != 0) align_viol++;
      pend = 2; last_w = 0;
    end else if (fl_we) begin
      if (pend == 2) begin
        if (!(fl_addr == '0 && fl_wdata == 8'hF0)) viol++;
        pend = 1;
      end else if (pend == 1) begin
        if (!(fl_addr == '0 && fl_wdata == 8'hFF)) viol++;
        pend = 0;
      end else if (fl_wdata == 8'h98 && int'(fl_addr) % 85 == 0) last_w = int'(fl_addr) / 85;
      else viol++;
    end
  end

  int total = 0, bad = 0;
  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [15:0] rc [6], rs [6];
  logic [15:0] p_cmd, p_ifc;
  logic [7:0] p_sz, p_n;

  task automatic fill(input bit okq, input bit okr, input bit oky);
    for (int i = 0; i < 80; i++) tbl[i] = 8'h00;
    tbl[16] = okq ? 8'h51 : 8'h50;
    tbl[17] = okr ? 8'h52 : 8'h53;
    tbl[18] = oky ? 8'h59 : 8'h58;
    tbl[19] = p_cmd[7:0]; tbl[20] = p_cmd[15:8];
    tbl[39] = p_sz;
    tbl[40] = p_ifc[7:0]; tbl[41] = p_ifc[15:8];
    tbl[44] = p_n;
    for (int r = 0; r < 6; r++) begin
      if (r < int'(p_n)) begin
        tbl[45+4*r] = rc[r][7:0]; tbl[46+4*r] = rc[r][15:8];
        tbl[47+4*r] = rs[r][7:0]; tbl[48+4*r] = rs[r][15:8];
      end
    end
  endtask

  // independent prediction
  bit e_err; int e_cause, e_w, e_reads; string e_tag;
  task automatic predict(input int cfg);
    bit found = 0; logic [15:0] inc;
    e_reads = 0; e_err = 0; e_cause = 0; e_tag = "R2";
    if (cfg == 1 || cfg == 2 || cfg == 4) begin
      e_w = cfg; e_reads = 1; found = (cfg == tw) && tbl[16] == 8'h51;
    end else begin
      for (int w = 1; w <= 4; w = w * 2) begin
        e_reads++; e_w = w;
        if (w == tw && tbl[16] == 8'h51) begin found = 1; break; end
      end
    end
    if (!found) begin e_err = 1; e_cause = 0; e_tag = "R3"; return; end
    e_reads++;
    if (tbl[17] != 8'h52) begin e_err = 1; e_cause = 1; e_tag = "R4"; return; end
    e_reads++;
    if (tbl[18] != 8'h59) begin e_err = 1; e_cause = 1; e_tag = "R4"; return; end
    e_reads += 5;
    inc = p_ifc + 16'd1;
    if ((inc & 16'(e_w)) == 0) begin e_err = 1; e_cause = 2; e_tag = "R7"; return; end
    e_reads++;
    if (p_n > 4) begin e_err = 1; e_cause = 3; e_tag = "R8"; return; end
    e_reads += 4 * int'(p_n);
  endtask

  task automatic run_case(input int t_w, input int cfg, input bit by_reset, input bit poke);
    bit seen = 0;
    tw = t_w; cfg_width = 3'(cfg);
    predict(cfg);
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
    if (by_reset) begin
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R11 reset done", done, 0); chk("R11 reset err", err, 0);
      chk("R11 reset we", fl_we, 0); chk("R11 reset re", fl_re, 0);
      rst = 1'b0;
    end else begin
      start = 1'b1; @(negedge clk); start = 1'b0;
      chk("R11 start clears done", done, 0);
      chk("R11 start clears err", err, 0);
    end
    if (poke) begin
      repeat (30) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    for (int i = 0; i < 5000; i++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    chk("R11 watchdog done seen", seen, 1);
    chk({e_tag, " err"}, err, e_err);
    if (e_err) chk({e_tag, " cause"}, err_cause, e_cause);
    chk("R1 read count", reads, e_reads);
    chk("R1 bracket order", viol, 0);
    chk("R10 alignment", align_viol, 0);
    if (!e_err) begin
      chk("R2 width", det_width, e_w);
      chk("R5 cmd set", cmd_set, p_cmd);
      chk("R6 size", dev_size, (p_sz < 32) ? (64'd1 << p_sz) : 64'd0);
      chk("R8 region count", region_num, p_n);
      for (int r = 0; r < MAX_REG; r++) begin
        chk("R9 blocks", blk_count_flat[r*17 +: 17], (r < int'(p_n)) ? 64'(rc[r]) + 1 : 0);
        chk("R9 block size", blk_size_flat[r*24 +: 24],
            (r < int'(p_n)) ? ((rs[r] == 0) ? 64'd128 : 64'(rs[r]) * 256) : 0);
      end
    end
  endtask

  task automatic std_params(input int n);
    p_cmd = 16'h0002; p_sz = 8'd23; p_ifc = 16'h0002; p_n = 8'(n);
    for (int r = 0; r < 6; r++) begin rc[r] = 16'(r * 7 + 3); rs[r] = 16'(r + 1); end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // directed corners
    std_params(2); fill(1, 1, 1); run_case(2, 0, 1, 0);         // reset start, auto x2
    std_params(4); rs[2] = 0; p_ifc = 16'h0005; fill(1, 1, 1); run_case(4, 0, 0, 0); // R9 zero size, max regions
    std_params(1); fill(1, 1, 1); run_case(8, 0, 0, 0);         // R3 no width
    std_params(1); fill(1, 1, 1); run_case(1, 2, 0, 0);         // R3 preset mismatch
    std_params(1); p_ifc = 16'h0003; fill(1, 1, 1); run_case(4, 4, 0, 0);
    std_params(1); fill(1, 1, 0); run_case(2, 0, 0, 0);         // R4 bad Y
    std_params(1); fill(1, 0, 1); run_case(1, 0, 0, 0);         // R4 bad R
    std_params(1); p_ifc = 16'hFFFF; fill(1, 1, 1); run_case(2, 0, 0, 0); // R7 wrap
    std_params(1); p_ifc = 16'h0001; fill(1, 1, 1); run_case(1, 0, 0, 0); // R7 mismatch
    std_params(5); fill(1, 1, 1); run_case(2, 0, 0, 0);         // R8 too many
    std_params(0); p_sz = 8'd40; fill(1, 1, 1); run_case(1, 0, 0, 0); // R8 zero, R6 overflow
    std_params(3); fill(1, 1, 1); run_case(2, 0, 0, 1);         // R11 start while busy
    // random
    for (int k = 0; k < 40; k++) begin
      int t, c, rr;
      t = (($urandom % 12) == 0) ? 8 : (1 << ($urandom % 3));
      rr = $urandom % 8;
      c = (rr < 6) ? 0 : (rr == 6) ? t : (1 << ($urandom % 3));
      p_cmd = 16'($urandom); p_sz = 8'($urandom % 40); p_n = 8'($urandom % 6);
      p_ifc = 16'($urandom);
      if (($urandom % 4) != 0) p_ifc = 16'((p_ifc | 16'(t)) - 16'd1);
      for (int r = 0; r < 6; r++) begin
        rc[r] = 16'($urandom);
        rs[r] = (($urandom % 4) == 0) ? 16'd0 : 16'($urandom);
      end
      fill(1, ($urandom % 10) != 0, ($urandom % 10) != 0);
      run_case(t, c, 0, 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule